// File: doc/BRIEF.md
# Write-Busy Status Read Path

This block is the read side of a byte-wide nonvolatile memory macro while an internal programming cycle may be running. On every read access it decides what the data bus carries: the stored byte from the array when the memory is idle, or a status word when the programming engine reports busy. The status word gives the host two ways to find out when a write has ended. The top bit is a polling bit: on a read of the byte that was written last, it returns the inverse of that byte's top bit. The next bit is a toggle bit that changes level on each new read access while the engine is busy.

The array, the page load buffer and the programming timer sit outside this block. They supply the busy flag, the address of the last written byte, the top bit of that byte and the array read data for the current address. A read access exists only while both active-low selects are low. The block drives a separate output-enable so the pad ring can tri-state the bus. All outputs are registered and follow the sampled inputs by one clock. The reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `wsr_top`

## Requirements
- R1: `dq_oe` is 1 in the cycle after a clock edge at which `ce_n` and `oe_n` were both 0. It is 0 after any edge at which either of them was 1, and it is 0 after reset.
- R2: `dq_out` is all zeros whenever `dq_oe` is 0.
- R3: While `busy` is 1, a read of the address equal to `last_addr` returns bit DW-1 as the inverse of `last_msb`.
- R4: While `busy` is 1, a read of any other address returns 0 in bit DW-1.
- R5: The toggle bit is bit DW-2. Its register resets to 0. It inverts once at the start of each busy read access. An access starts at the first edge at which both selects are low after an edge at which they were not. The bit holds its level for the rest of that access, so the first busy access after reset reads 1.
- R6: While `busy` is 1, bits DW-3 down to 0 of a read are 0.
- R7: While `busy` is 0, a read returns `array_rdata`. The toggle register does not change, so the next busy access reads the inverse of the level seen on the previous busy access.
- R8: Every output reflects the inputs sampled at the previous clock edge. A change of address or of `busy` in the middle of an access shows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable request |
| rd_addr | input | AW | Read address |
| busy | input | 1 | Programming cycle in progress |
| last_addr | input | AW | Address of the last written byte |
| last_msb | input | 1 | Top bit of the last written byte |
| array_rdata | input | DW | Array contents at `rd_addr` |
| dq_out | output | DW | Data driven toward the bus |
| dq_oe | output | 1 | Bus drive enable (0 = high impedance) |

## Verification
A wrong state in the access edge register shows up in the toggle bit on the first busy read after the fault. The bit either fails to change between two accesses or changes within one held access, which is visible one cycle after the select edge. A corrupted toggle register shows as the wrong absolute level on the next busy access. A bad source selection shows at once as the wrong top bit or as nonzero low bits on a single read. The bench walks every address in both busy states. It compares each read against a toggle level it tracks itself from the count of busy accesses.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_POLL   = 2'd2,
    SRC_STATUS = 2'd3
  } wsr_src_e;
endpackage

// File: rtl/wsr_rst_sync.sv
module wsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wsr_access_detect.sv
module wsr_access_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  output logic rd_act,
  output logic rd_start
);
  logic act_q;
  logic act_d;

  assign rd_act = ~ce_n & ~oe_n;

  always_comb begin
    act_d    = rd_act;
    rd_start = rd_act & ~act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end
endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_start,
  input  logic busy,
  output logic tgl_next
);
  logic tgl_q;
  logic flip_en;

  always_comb begin
    flip_en  = rd_start & busy;
    tgl_next = flip_en ? ~tgl_q : tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tgl_q <= 1'b0;
    else if (flip_en) tgl_q <= tgl_next;
  end
endmodule

// File: rtl/wsr_word_mux.sv
module wsr_word_mux
  import wsr_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          rd_act,
  input  logic          busy,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] last_addr,
  input  logic          last_msb,
  input  logic          tgl,
  input  logic [DW-1:0] array_rdata,
  output logic [DW-1:0] word
);
  localparam int POLL_BIT = DW - 1;
  localparam int TGL_BIT  = DW - 2;

  wsr_src_e src;
  logic     addr_hit;

  always_comb begin
    addr_hit = (rd_addr == last_addr);
    if (!rd_act)       src = SRC_NONE;
    else if (!busy)    src = SRC_ARRAY;
    else if (addr_hit) src = SRC_POLL;
    else               src = SRC_STATUS;
  end

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      always_comb begin
        unique case (src)
          SRC_ARRAY: word[i] = array_rdata[i];
          SRC_POLL:  word[i] = ~last_msb;
          default:   word[i] = 1'b0;
        endcase
      end
    end else if (i == TGL_BIT) begin : g_tgl
      always_comb begin
        unique case (src)
          SRC_ARRAY:           word[i] = array_rdata[i];
          SRC_POLL, SRC_STATUS: word[i] = tgl;
          default:             word[i] = 1'b0;
        endcase
      end
    end else begin : g_rsvd
      always_comb begin
        word[i] = (src == SRC_ARRAY) ? array_rdata[i] : 1'b0;
      end
    end
  end
endmodule

// File: rtl/wsr_top.sv
module wsr_top #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [AW-1:0] rd_addr,
  input  logic          busy,
  input  logic [AW-1:0] last_addr,
  input  logic          last_msb,
  input  logic [DW-1:0] array_rdata,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  logic          rst_q_n;
  logic          rd_act;
  logic          rd_start;
  logic          tgl_next;
  logic [DW-1:0] word_d;
  logic [DW-1:0] dq_q;
  logic          oe_q;

  wsr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  wsr_access_detect u_acc (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .rd_act   (rd_act),
    .rd_start (rd_start)
  );

  wsr_toggle u_tgl (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .rd_start (rd_start),
    .busy     (busy),
    .tgl_next (tgl_next)
  );

  wsr_word_mux #(.AW(AW), .DW(DW)) u_mux (
    .rd_act      (rd_act),
    .busy        (busy),
    .rd_addr     (rd_addr),
    .last_addr   (last_addr),
    .last_msb    (last_msb),
    .tgl         (tgl_next),
    .array_rdata (array_rdata),
    .word        (word_d)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      dq_q <= '0;
      oe_q <= 1'b0;
    end else begin
      dq_q <= word_d;
      oe_q <= rd_act;
    end
  end

  assign dq_out = dq_q;
  assign dq_oe  = oe_q;
endmodule

// File: rtl/wsr_chk.sv
module wsr_chk #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic [AW-1:0] rd_addr,
  input logic          busy,
  input logic [AW-1:0] last_addr,
  input logic          last_msb,
  input logic [DW-1:0] array_rdata,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe
);
  logic rd;
  logic rd_prev;
  logic bstart;
  logic pend;
  logic seen;
  logic last6;

  assign rd     = ~ce_n & ~oe_n;
  assign bstart = rd & ~rd_prev & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev <= 1'b0;
      pend    <= 1'b0;
      seen    <= 1'b0;
      last6   <= 1'b0;
    end else begin
      rd_prev <= rd;
      pend    <= bstart;
      if (pend) begin
        seen  <= 1'b1;
        last6 <= dq_out[DW-2];
      end
    end
  end

  AST_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> dq_oe); // R1
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !dq_oe); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0)); // R2
  AST_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && busy && rd_addr == last_addr) |=> (dq_out[DW-1] == !$past(last_msb))); // R3
  AST_POLL_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && busy && rd_addr != last_addr) |=> !dq_out[DW-1]); // R4
  AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (bstart && seen) |=> (dq_out[DW-2] != last6)); // R5
  AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && rd_prev && busy && $past(busy)) |=> $stable(dq_out[DW-2])); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && busy) |=> (dq_out[DW-3:0] == '0)); // R6
  AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !busy) |=> (dq_out == $past(array_rdata))); // R7
endmodule

bind wsr_top wsr_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .ce_n        (ce_n),
  .oe_n        (oe_n),
  .rd_addr     (rd_addr),
  .busy        (busy),
  .last_addr   (last_addr),
  .last_msb    (last_msb),
  .array_rdata (array_rdata),
  .dq_out      (dq_out),
  .dq_oe       (dq_oe)
);

// File: tb/tb_wsr_top.sv
`timescale 1ns/1ps
module tb_wsr_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam logic [AW-1:0] LAST = 4'd5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, busy, last_msb;
  logic [AW-1:0] rd_addr, last_addr;
  logic [DW-1:0] array_rdata;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int n_run  = 0;
  int n_fail = 0;
  logic exp_t = 1'b0;
  logic prev_t;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] arr_of(logic [AW-1:0] a);
    return DW'(a * 37 + 11);
  endfunction

  assign array_rdata = arr_of(rd_addr);

  wsr_top #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .rd_addr(rd_addr),
    .busy(busy), .last_addr(last_addr), .last_msb(last_msb),
    .array_rdata(array_rdata), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(string req, logic [DW:0] act, logic [DW:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] busy_word(logic [AW-1:0] a, logic msb, logic t);
    return {(a == LAST) ? ~msb : 1'b0, t, 6'b0};
  endfunction

  task automatic rd_begin(logic [AW-1:0] a);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; rd_addr = a;
    if (busy) exp_t = ~exp_t;
    @(posedge clk); #1;
  endtask

  task automatic rd_end();
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(posedge clk); #1;
    chk("R1/R2 idle after access", {dq_oe, dq_out}, '0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; busy = 1'b0;
    rd_addr = '0; last_addr = LAST; last_msb = 1'b0; exp_t = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1/R2 reset state", {dq_oe, dq_out}, '0);

    // R7: idle reads of every address return array data
    for (int a = 0; a < 16; a++) begin
      rd_begin(AW'(a));
      chk("R7 array read", {dq_oe, dq_out}, {1'b1, arr_of(AW'(a))});
      rd_end();
    end

    // R8: address change mid access shows one cycle later
    rd_begin(4'd2);
    @(negedge clk); rd_addr = 4'd9;
    #1 chk("R8 output held before edge", {dq_oe, dq_out}, {1'b1, arr_of(4'd2)});
    @(posedge clk); #1;
    chk("R8 new address after one edge", {dq_oe, dq_out}, {1'b1, arr_of(4'd9)});
    rd_end();

    // R1: only one select low is no access
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
    @(posedge clk); #1 chk("R1 ce only", {dq_oe, dq_out}, '0);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
    @(posedge clk); #1 chk("R1 oe only", {dq_oe, dq_out}, '0);
    @(negedge clk); oe_n = 1'b1;

    // R3 R4 R5 R6: busy sweep over addresses and both polarities
    busy = 1'b1;
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 16; a++) begin
        @(negedge clk); last_msb = m[0];
        rd_begin(AW'(a));
        chk("R3/R4/R5/R6 busy status word", {dq_oe, dq_out},
            {1'b1, busy_word(AW'(a), m[0], exp_t)});
        rd_end();
      end
    end

    // R5: bit stays constant within a held access
    rd_begin(LAST);
    prev_t = exp_t;
    repeat (3) begin
      @(posedge clk); #1;
      chk("R5 toggle held within access", {1'b0, dq_out}, {1'b0, busy_word(LAST, last_msb, prev_t)});
    end
    // R7 R8: busy falls while read is held
    @(negedge clk); busy = 1'b0;
    @(posedge clk); #1;
    chk("R7 busy falls mid access", {dq_oe, dq_out}, {1'b1, arr_of(LAST)});
    rd_end();

    // R7: idle reads do not move the toggle
    for (int k = 0; k < 5; k++) begin
      rd_begin(AW'(k));
      chk("R7 idle read during gap", {dq_oe, dq_out}, {1'b1, arr_of(AW'(k))});
      rd_end();
    end
    @(negedge clk); busy = 1'b1;
    rd_begin(4'd3);
    chk("R7/R5 toggle resumes inverted", {1'b0, dq_out[DW-2]}, {8'b0, ~prev_t});
    rd_end();

    // R5: reset brings the toggle back to 0, first busy read gives 1
    do_reset();
    busy = 1'b1;
    rd_begin(4'd0);
    chk("R5 first busy read after reset", {1'b0, dq_out}, {1'b0, 8'h40});
    rd_end();
    rd_begin(4'd0);
    chk("R5 second busy read after reset", {1'b0, dq_out}, {1'b0, 8'h00});
    rd_end();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule